// File: doc/BRIEF.md
# Symbol Clock Recovery From Oversampled Data

This block recovers symbol timing from a stream of hard decisions that arrives at an oversampling rate of 32 ticks per symbol. A free-running phase counter advances on each tick. Whenever the input changes level, the counter is pulled one tick toward the point where a symbol boundary should fall. When the counter reaches mid-symbol, the block emits a one-clock symbol strobe and captures the input as the retimed data bit.

The same loop serves any upstream demodulation scheme, because it only looks at level changes. A lock flag reports that edges have kept arriving close to their ideal position. The flag drops when the input has been silent for a long stretch of symbols. The tick enable lets the block share a fast system clock. Nothing in the block moves on a clock where the enable is low.

Top module: `symbol_clock_recovery`

## Requirements
- R1: Reset clears the phase counter to 0. Each tick (tickEn high at a rising clock edge) advances the counter by one modulo 32, unless R3 applies. symStrobe is high for exactly one clock after each tick on which the counter reads 16. With a constant input, the first strobe follows the 17th tick after reset, and later strobes are 32 ticks apart.
- R2: A transition is a tick on which dataIn differs from its value at the previous tick. The reference value after reset is 0.
- R3: On a transition tick, the counter value c before the update decides the correction. If c = 0, the counter advances by 1. If c is from 1 to 16, the counter holds. If c is from 17 to 31, the counter advances by 2.
- R4: On the clock where the strobe is raised, dataOut takes the dataIn level sampled on that tick. At all other times dataOut holds its value.
- R5: A transition is good when c is one of 30, 31, 0, 1 or 2. locked rises on the eighth consecutive good transition. Any other transition restarts the count.
- R6: While locked, locked falls on the 64th strobe in a row that has no transition in between. The good-transition count also restarts at that point.
- R7: With an alternating input whose symbol period is 31 or 33 ticks (about ±3%), the loop locks. Every strobe then lands inside a symbol, so dataOut equals the level being sent.
- R8: When tickEn is low, the counter, the reference value, dataOut, locked and the strobe do not change, and no strobe is raised.
- R9: During and straight after reset, symStrobe, dataOut and locked are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Oversampling tick, 32 per symbol |
| dataIn | input | 1 | Hard-decided input bit |
| symStrobe | output | 1 | One-clock pulse at mid-symbol |
| dataOut | output | 1 | Retimed data bit |
| locked | output | 1 | Timing lock indicator |

## Verification
The bench places single transitions at chosen counter values: 0, both sides of the late/early boundary, and near the wrap. It then measures the distance to the next strobe. A design that corrects in the wrong direction, or on the wrong side of 16, shifts that distance by two ticks. The lock threshold is probed one edge short and exactly at eight, including a run that one far-off edge breaks. An off-by-one counter would assert lock early or late. The silence timeout is checked at the 63rd and 64th strobe. The rate-offset runs and the half-rate tick pattern expose a loop that cannot pull in, or one that advances without a tick.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // Events passed from the datapath to the lock controller each clock.
  typedef struct packed {
    logic edgeSeen;    // transition on this tick
    logic edgeGood;    // transition within lock tolerance
    logic symbolTick;  // mid-symbol sampling tick
  } cdrEvents_t;
endpackage

// File: rtl/cdr_datapath.sv
module cdr_datapath
  import cdr_pkg::*;
#(
  parameter int PHASE_W = 5,
  parameter int LOCK_TOL = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       dataIn,
  output cdrEvents_t evt,
  output logic       symStrobe,
  output logic       dataOut
);
  localparam int OSR = 1 << PHASE_W;
  localparam logic [PHASE_W-1:0] MID = PHASE_W'(OSR / 2);
  localparam logic [PHASE_W-1:0] TOL = PHASE_W'(LOCK_TOL);
  localparam logic [PHASE_W-1:0] TOL_HI = PHASE_W'(OSR - LOCK_TOL);

  logic [PHASE_W-1:0] phase, phaseNext;
  logic prevBit;
  logic edgeNow, sampleNow;

  assign edgeNow   = tickEn && (dataIn != prevBit);
  assign sampleNow = tickEn && (phase == MID);

  always_comb begin
    phaseNext = phase;
    if (tickEn) begin
      if (!edgeNow || phase == '0) phaseNext = phase + 1'b1;
      else if (phase <= MID)       phaseNext = phase;
      else                         phaseNext = phase + PHASE_W'(2);
    end
  end

  always_comb begin
    evt.edgeSeen   = edgeNow;
    evt.edgeGood   = edgeNow && ((phase <= TOL) || (phase >= TOL_HI));
    evt.symbolTick = sampleNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      prevBit   <= 1'b0;
      symStrobe <= 1'b0;
      dataOut   <= 1'b0;
    end else begin
      phase     <= phaseNext;
      symStrobe <= sampleNow;
      if (tickEn) prevBit <= dataIn;
      if (sampleNow) dataOut <= dataIn;
    end
  end

  // R1: strobe is a single-clock pulse
  assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |=> !symStrobe);
  // R4: retimed bit only moves with the strobe
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !symStrobe |-> $stable(dataOut));
  // R3: a late edge holds the counter
  assert_late_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeNow && phase != '0 && phase <= MID) |=> (phase == $past(phase)));
  // R8: nothing moves without a tick
  assert_tick_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(phase) && $stable(prevBit) && !symStrobe));
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
  import cdr_pkg::*;
#(
  parameter int LOCK_EDGES = 8,
  parameter int SILENT_SYMS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  cdrEvents_t evt,
  output logic       locked
);
  localparam int GOOD_W = $clog2(LOCK_EDGES + 1);
  localparam int SIL_W  = $clog2(SILENT_SYMS + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_EDGES - 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(LOCK_EDGES);
  localparam logic [SIL_W-1:0]  SIL_LAST  = SIL_W'(SILENT_SYMS - 1);

  logic [GOOD_W-1:0] goodCnt;
  logic [SIL_W-1:0]  silentCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt   <= '0;
      silentCnt <= '0;
      locked    <= 1'b0;
    end else if (evt.edgeSeen) begin
      silentCnt <= '0;
      if (evt.edgeGood) begin
        if (goodCnt == GOOD_LAST) locked <= 1'b1;
        if (goodCnt != GOOD_MAX) goodCnt <= goodCnt + 1'b1;
      end else begin
        goodCnt <= '0;
      end
    end else if (evt.symbolTick) begin
      if (silentCnt == SIL_LAST) begin
        silentCnt <= '0;
        goodCnt   <= '0;
        locked    <= 1'b0;
      end else begin
        silentCnt <= silentCnt + 1'b1;
      end
    end
  end

  // R5: lock only rises on a good transition
  assert_lock_on_good_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(evt.edgeGood));
  // R6: lock only falls on a silent symbol tick
  assert_unlock_on_silence_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(evt.symbolTick) && !$past(evt.edgeSeen)));
endmodule

// File: rtl/symbol_clock_recovery.sv
module symbol_clock_recovery
  import cdr_pkg::*;
#(
  parameter int PHASE_W = 5,
  parameter int LOCK_TOL = 2,
  parameter int LOCK_EDGES = 8,
  parameter int SILENT_SYMS = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic dataIn,
  output logic symStrobe,
  output logic dataOut,
  output logic locked
);
  cdrEvents_t evt;

  cdr_datapath #(.PHASE_W(PHASE_W), .LOCK_TOL(LOCK_TOL)) uDatapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataIn(dataIn),
    .evt(evt), .symStrobe(symStrobe), .dataOut(dataOut)
  );

  cdr_lock_ctrl #(.LOCK_EDGES(LOCK_EDGES), .SILENT_SYMS(SILENT_SYMS)) uLockCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .locked(locked)
  );
endmodule

// File: tb/symbol_clock_recovery_test.sv
module symbol_clock_recovery_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // transition placed at counter value, expected ticks from edge to strobe
  localparam int VEC_OFS [NVEC] = '{0, 2, 5, 10, 17, 20, 30, 31};
  localparam int VEC_EXP [NVEC] = '{16, 15, 12, 7, 30, 27, 17, 16};

  logic clk = 0, rstN = 0, tickEn = 1, dataIn = 0;
  logic symStrobe, dataOut, locked;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  symbol_clock_recovery uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataIn(dataIn),
    .symStrobe(symStrobe), .dataOut(dataOut), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rstN = 0; tickEn = 1; dataIn = 0;
    repeat (3) step();
    rstN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int firstS, secondS, cnt;
    // R9: reset state
    doReset();
    check(symStrobe == 0 && dataOut == 0 && locked == 0, "R9", {symStrobe, dataOut, locked}, 0);

    // R1: free-running strobe position and spacing
    firstS = -1; secondS = -1;
    for (int i = 0; i < 80; i++) begin
      step();
      if (symStrobe) begin
        if (firstS < 0) firstS = i; else if (secondS < 0) secondS = i;
      end
    end
    check(firstS == 16, "R1 first strobe", firstS, 16);
    check(secondS - firstS == 32, "R1 spacing", secondS - firstS, 32);

    // R2/R3/R4: single transition at chosen counter value
    for (int v = 0; v < NVEC; v++) begin
      int p;
      doReset();
      repeat (VEC_OFS[v]) step();
      dataIn = 1;
      p = -1;
      for (int i = 0; i < 40 && p < 0; i++) begin
        step();
        if (symStrobe) begin
          if (VEC_OFS[v] < 16 || i > 0) p = i;
        end
      end
      check(p == VEC_EXP[v], "R3 correction", p, VEC_EXP[v]);
      check(dataOut == 1, "R4 retimed bit", dataOut, 1);
    end

    // R5: lock after eight good edges, and R6 unlock after 64 silent strobes
    doReset();
    for (int k = 0; k < 8; k++) begin
      dataIn = ~dataIn; step();
      if (k == 6) check(locked == 0, "R5 seven edges", locked, 0);
      if (k == 7) check(locked == 1, "R5 eight edges", locked, 1);
      if (k < 7) repeat (31) step();
    end
    cnt = 0;
    while (cnt < 64) begin
      step();
      if (symStrobe) begin
        cnt++;
        if (cnt == 63) check(locked == 1, "R6 63 strobes", locked, 1);
        if (cnt == 64) check(locked == 0, "R6 64 strobes", locked, 0);
      end
    end

    // R5: one far-off edge breaks the run
    doReset();
    for (int k = 0; k < 7; k++) begin
      dataIn = ~dataIn; step();
      if (k < 6) repeat (31) step();
    end
    repeat (7) step();
    dataIn = ~dataIn; step();              // counter reads 8: bad edge
    repeat (24) step();
    for (int k = 0; k < 8; k++) begin
      dataIn = ~dataIn; step();
      if (k == 6) check(locked == 0, "R5 run restarted", locked, 0);
      if (k == 7) check(locked == 1, "R5 relock", locked, 1);
      if (k < 7) repeat (31) step();
    end

    // R7: rate offset tracking
    for (int r = 0; r < 2; r++) begin
      int period = (r == 0) ? 31 : 33;
      int bad = 0;
      cnt = 0;
      doReset();
      for (int s = 0; s < 40; s++) begin
        dataIn = ~dataIn;
        for (int t = 0; t < period; t++) begin
          step();
          if (symStrobe) begin
            cnt++;
            if (dataOut != dataIn) bad++;
          end
        end
      end
      check(locked == 1, "R7 locked", locked, 1);
      check(bad == 0, "R7 data match", bad, 0);
      check(cnt >= 39 && cnt <= 41, "R7 strobe count", cnt, 40);
    end

    // R8: half-rate ticks stretch the strobe spacing
    doReset();
    firstS = -1; secondS = -1; cnt = 0;
    for (int i = 0; i < 200; i++) begin
      tickEn = (i % 2 == 0);
      step();
      if (symStrobe) begin
        cnt++;
        if (firstS < 0) firstS = i; else if (secondS < 0) secondS = i;
      end
    end
    check(secondS - firstS == 64, "R8 gated spacing", secondS - firstS, 64);
    check(cnt == 3, "R8 gated strobe count", cnt, 3);
    tickEn = 0;
    repeat (40) begin
      dataIn = ~dataIn; step();
    end
    check(symStrobe == 0 && locked == 0, "R8 no tick no change", symStrobe, 0);

    finishRun();
  end
endmodule